// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the serial front end of a two-wire EEPROM. It oversamples SCL and SDA with a fast system clock and finds start and stop conditions. It moves bytes in and out of the chip and controls SDA through an open-drain pull-down enable. It decodes the device-select byte and the two word-address bytes, and it keeps the internal address pointer. Read data comes from a synchronous memory read port. Each received write byte goes out on a one-cycle request port to a separate page-programming block, and a commit strobe marks the stop that ends a write.

The engine covers byte writes, page writes, current-address reads, random reads and sequential reads. A random read is a write framing that carries only the address, followed by a repeated start and a read select. While the programming block reports busy, the engine does not acknowledge its select byte, so the master can poll until the write finishes.

Top module: `tweSlave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Before the first start the engine never drives SDA and issues no write request.
- R2: The select byte matches only when, MSB first, it holds 1010, then the A2 strap, then the A1 strap, then address bit 16, then R/W (1 = read). A select byte that does not match is not acknowledged, and the engine ignores the bus until the next start.
- R3: After a matching select byte, and after each address or write-data byte, the engine pulls SDA low for the ninth clock. It releases SDA at the SCL fall that ends that clock.
- R4: A write framing gives the word address high byte first. Address bit 16 comes from the select byte. Each data byte then gives exactly one single-cycle `wrReqValid` pulse carrying that 17-bit address and the byte.
- R5: During a page write the low 8 address bits advance after each data byte and wrap inside the 256-byte page. The upper bits do not change.
- R6: `wrCommit` pulses once at a stop that ends a framing which carried at least one data byte. A framing that carries only an address gives no commit and no request.
- R7: A current-address read returns the byte at one past the last byte accessed. This holds after both writes and reads.
- R8: A random read (address-only write, repeated start, read select) returns data from the supplied address.
- R9: A master ACK after a read byte makes the engine send the next byte. After a master NACK the engine no longer drives SDA.
- R10: The read address advances linearly and wraps from 0x1FFFF to 0x00000.
- R11: While `wrBusy` is high the select byte is not acknowledged.
- R12: A start that arrives in the middle of a byte discards the partial byte and restarts select decoding.
- R13: Address bit 16 of a read select byte replaces bit 16 of the pointer before the data is read.
- R14: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| strapA1 | input | 1 | Hardware address strap A1 |
| strapA2 | input | 1 | Hardware address strap A2 |
| wrBusy | input | 1 | Internal write cycle in progress |
| sdaOe | output | 1 | 1 pulls SDA low |
| memRdEn | output | 1 | Memory read enable |
| memRdAddr | output | 17 | Memory read address |
| memRdData | input | 8 | Read data, valid the cycle after the enable |
| wrReqValid | output | 1 | One-cycle pulse per received data byte |
| wrReqAddr | output | 17 | Target address of the request |
| wrReqData | output | 8 | Data byte of the request |
| wrCommit | output | 1 | Stop ended a write framing that carried data |

## Verification
The bench targets the following corner cases.
- A page write that crosses the end of a page. A design that increments all 17 bits would send the third byte to 0x00100 instead of 0x00000.
- A read at 0x1FFFF that continues after an ACK. A wrong wrap shows up as data from a wrong address.
- A current-address read whose select bit 16 differs from the pointer. A design that keeps the old bit returns the low-half byte.
- An address-only framing followed by a stop. A design that commits there raises a spurious commit.
- A start injected three bits into a byte. A design that does not clear the bit count misreads the next select byte and never acknowledges.
- Busy polling, straps that do not match, and clocking with no start before it. Each of these must stay silent.

// File: rtl/twe_pkg.sv
`timescale 1ns/1ps
package twe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tweState_t;

  typedef enum logic [1:0] {
    K_SEL,
    K_AHI,
    K_ALO,
    K_DATA
  } tweKind_t;

  typedef struct packed {
    logic shiftIn;
    logic cntClr;
    logic cntInc;
    logic latchSel;
    logic setHiBit;
    logic loadHi;
    logic loadLo;
    logic incPage;
    logic incLin;
    logic loadTx;
    logic shiftTx;
  } tweStrobe_t;

endpackage

// File: rtl/tweDatapath.sv
`timescale 1ns/1ps
module tweDatapath import twe_pkg::*; #(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  tweStrobe_t        stb,
  input  logic [6:0]        rdLow,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaS,
  output logic [7:0]        rxByte,
  output logic [3:0]        bitCnt,
  output logic              txNext,
  output logic [ADDR_W-1:0] ptr
);
  localparam int WORD_W = ADDR_W - 1;

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sclQ, sdaQ, selBit;
  logic [6:0] txRest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclQ  <= sclS;
      sdaQ  <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
      txRest <= '0;
      selBit <= 1'b0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaS};
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntInc) bitCnt <= bitCnt + 4'd1;
      if (stb.loadTx)       txRest <= rdLow;
      else if (stb.shiftTx) txRest <= {txRest[5:0], 1'b0};
      if (stb.latchSel) selBit <= rxByte[1];
    end
  end

  assign txNext = txRest[6];

  // address pointer: only one strobe is active in any cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.setHiBit) begin
      ptr[ADDR_W-1] <= rxByte[1];
    end else if (stb.loadHi) begin
      ptr[ADDR_W-1]       <= selBit;
      ptr[WORD_W-1 -: 8]  <= rxByte;
    end else if (stb.loadLo) begin
      ptr[7:0] <= rxByte;
    end else if (stb.incPage) begin
      ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
    end else if (stb.incLin) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tweControl.sv
`timescale 1ns/1ps
module tweControl import twe_pkg::*; #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic       txNext,
  input  logic       rdMsb,
  input  logic       strapA1,
  input  logic       strapA2,
  input  logic       wrBusy,
  output tweStrobe_t stb,
  output logic       sdaOe,
  output logic       memRdEn,
  output logic       wrReqValid,
  output logic       wrCommit
);
  tweState_t state, stateN;
  tweKind_t  kind, kindN;
  logic rdMode, rdN, gotData, gotN, mAck, mAckN, oeN, selMatch, byteDone;

  assign selMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3] == strapA2) && (rxByte[2] == strapA1);
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign memRdEn  = rdMode && (state == ST_ACK || state == ST_TX || state == ST_MACK);

  always_comb begin
    stb = '0;
    stateN = state; kindN = kind; rdN = rdMode; gotN = gotData; mAckN = mAck; oeN = sdaOe;
    wrReqValid = 1'b0;
    wrCommit   = 1'b0;
    if (stopDet) begin
      stateN = ST_IDLE; oeN = 1'b0; wrCommit = gotData; gotN = 1'b0;
    end else if (startDet) begin
      stateN = ST_RX; kindN = K_SEL; stb.cntClr = 1'b1; oeN = 1'b0; rdN = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1; stb.cntInc = 1'b1;
          end else if (byteDone) begin
            case (kind)
              K_SEL: begin
                if (selMatch && !wrBusy) begin
                  oeN = 1'b1; stateN = ST_ACK;
                  if (rxByte[0]) begin
                    rdN = 1'b1; stb.setHiBit = 1'b1;
                  end else begin
                    stb.latchSel = 1'b1; kindN = K_AHI;
                  end
                end else begin
                  stateN = ST_IDLE;
                end
              end
              K_AHI: begin oeN = 1'b1; stateN = ST_ACK; stb.loadHi = 1'b1; kindN = K_ALO; end
              K_ALO: begin oeN = 1'b1; stateN = ST_ACK; stb.loadLo = 1'b1; kindN = K_DATA; end
              default: begin
                oeN = 1'b1; stateN = ST_ACK; wrReqValid = 1'b1; stb.incPage = 1'b1; gotN = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: if (sclFall) begin
          stb.cntClr = 1'b1;
          if (rdMode) begin
            stb.loadTx = 1'b1; stb.incLin = 1'b1; oeN = !rdMsb; stateN = ST_TX;
          end else begin
            oeN = 1'b0; stateN = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) stb.cntInc = 1'b1;
          else if (byteDone) begin oeN = 1'b0; stateN = ST_MACK; end
          else if (sclFall) begin stb.shiftTx = 1'b1; oeN = !txNext; end
        end
        ST_MACK: begin
          if (sclRise) mAckN = !sdaS;
          else if (sclFall) begin
            if (mAck) begin
              stb.cntClr = 1'b1; stb.loadTx = 1'b1; stb.incLin = 1'b1;
              oeN = !rdMsb; stateN = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; kind <= K_SEL; rdMode <= 1'b0;
      gotData <= 1'b0; mAck <= 1'b0; sdaOe <= 1'b0;
    end else begin
      state <= stateN; kind <= kindN; rdMode <= rdN;
      gotData <= gotN; mAck <= mAckN; sdaOe <= oeN;
    end
  end
endmodule

// File: rtl/tweSlave.sv
`timescale 1ns/1ps
module tweSlave import twe_pkg::*; #(
  parameter int         ADDR_W      = 17,
  parameter int         PAGE_BITS   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapA1,
  input  logic              strapA2,
  input  logic              wrBusy,
  output logic              sdaOe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              wrReqValid,
  output logic [ADDR_W-1:0] wrReqAddr,
  output logic [7:0]        wrReqData,
  output logic              wrCommit
);
  tweStrobe_t        stb;
  logic              sclRise, sclFall, startDet, stopDet, sdaS, txNext;
  logic [7:0]        rxByte;
  logic [3:0]        bitCnt;
  logic [ADDR_W-1:0] ptr;

  tweDatapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .rdLow(memRdData[6:0]), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .bitCnt(bitCnt), .txNext(txNext), .ptr(ptr)
  );

  tweControl #(.DEV_CODE(DEV_CODE)) i_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .rxByte(rxByte),
    .bitCnt(bitCnt), .txNext(txNext), .rdMsb(memRdData[7]),
    .strapA1(strapA1), .strapA2(strapA2), .wrBusy(wrBusy), .stb(stb),
    .sdaOe(sdaOe), .memRdEn(memRdEn), .wrReqValid(wrReqValid), .wrCommit(wrCommit)
  );

  assign memRdAddr = ptr;
  assign wrReqAddr = ptr;
  assign wrReqData = rxByte;
endmodule

// File: rtl/tweSlaveChk.sv
`timescale 1ns/1ps
module tweSlaveChk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic wrBusy,
  input logic wrReqValid,
  input logic wrCommit
);
  // R14
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReqValid |=> !wrReqValid);

  // R4
  req_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReqValid |-> !sclIn);

  // R6
  commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> (sclIn && !wrReqValid));

  // R6
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R11: busy is raised only between framings, so no pull-down may begin under it
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(wrBusy));
endmodule

bind tweSlave tweSlaveChk i_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .wrBusy(wrBusy),
  .wrReqValid(wrReqValid), .wrCommit(wrCommit)
);

// File: tb/test_tweSlave.sv
`timescale 1ns/1ps
module test_tweSlave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapA1 = 1'b0, strapA2 = 1'b1;
  logic wrBusy = 1'b0;
  logic sdaOe, memRdEn, wrReqValid, wrCommit;
  logic [16:0] memRdAddr, wrReqAddr;
  logic [7:0]  memRdData = 8'h00, wrReqData;
  wire sdaBus = sdaM & ~sdaOe;

  int nChk = 0, nErr = 0, nWr = 0, nCommit = 0, badOe = 0;
  logic [16:0] logA [16];
  logic [7:0]  logD [16];
  logic prevOe = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tweSlave i_tweSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapA1(strapA1),
    .strapA2(strapA2), .wrBusy(wrBusy), .sdaOe(sdaOe), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .wrReqValid(wrReqValid),
    .wrReqAddr(wrReqAddr), .wrReqData(wrReqData), .wrCommit(wrCommit)
  );

  function automatic logic [7:0] fmem(input logic [16:0] a);
    return a[7:0] + a[15:8] * 8'd3 + (a[16] ? 8'h5A : 8'h00);
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= fmem(memRdAddr);
    if (rstN) begin
      if (wrReqValid) begin
        if (nWr < 16) begin logA[nWr] = wrReqAddr; logD[nWr] = wrReqData; end
        nWr++;
      end
      if (wrCommit) nCommit++;
      if (sdaOe !== prevOe && sclM) badOe++;
    end
    prevOe = sdaOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q / 2); ack = !sdaBus; tick(Q / 2);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sclM = 1'b1; tick(Q); b = {b[6:0], sdaBus}; sclM = 1'b0;
    end
    tick(Q); sdaM = !ackIt; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q); sdaM = 1'b1;
  endtask

  task automatic tReset();
    chk("R1 reset sdaOe", sdaOe, 0);
    chk("R1 reset wrReqValid", wrReqValid, 0);
    chk("R6 reset wrCommit", wrCommit, 0);
  endtask

  task automatic tNoStart();
    logic a; int w0 = nWr;
    sendByte(8'hA8, a);
    sclM = 1'b1; tick(Q);
    chk("R1 no ack without start", a, 0);
    chk("R1 no request without start", nWr - w0, 0);
  endtask

  task automatic tWrongSel();
    logic a;
    busStart(); sendByte(8'hA0, a); chk("R2 wrong A2 nack", a, 0);
    sendByte(8'h00, a); chk("R2 later byte ignored", a, 0); busStop();
    busStart(); sendByte(8'hAC, a); chk("R2 wrong A1 nack", a, 0); busStop();
    busStart(); sendByte(8'hB8, a); chk("R2 wrong code nack", a, 0); busStop();
  endtask

  task automatic tByteWrite();
    logic a0, a1, a2, a3; int w0 = nWr, c0 = nCommit;
    busStart();
    sendByte(8'hAA, a0); sendByte(8'h12, a1); sendByte(8'h34, a2); sendByte(8'h5C, a3);
    chk("R3 select ack", a0, 1);
    chk("R3 address acks", {a1, a2}, 2'b11);
    chk("R3 data ack", a3, 1);
    chk("R3 released after ninth clock", sdaOe, 0);
    busStop(); tick(4);
    chk("R4 one request", nWr - w0, 1);
    chk("R4 request address", logA[w0], 17'h11234);
    chk("R4 request data", logD[w0], 8'h5C);
    chk("R6 commit after data", nCommit - c0, 1);
  endtask

  task automatic curRead(input logic [7:0] sel, input logic [16:0] exp, input string req);
    logic a; logic [7:0] d;
    busStart(); sendByte(sel, a); readByte(1'b0, d);
    chk(req, d, fmem(exp));
    chk("R9 released after nack", sdaOe, 0);
    busStop();
  endtask

  task automatic tPageWrap();
    logic a; int w0 = nWr, c0 = nCommit;
    busStart();
    sendByte(8'hA8, a); sendByte(8'h00, a); sendByte(8'hFE, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a);
    busStop(); tick(4);
    chk("R5 three requests", nWr - w0, 3);
    chk("R5 first addr", logA[w0], 17'h000FE);
    chk("R5 second addr", logA[w0 + 1], 17'h000FF);
    chk("R5 wrapped addr", logA[w0 + 2], 17'h00000);
    chk("R5 wrapped data", logD[w0 + 2], 8'h33);
    chk("R6 page commit", nCommit - c0, 1);
  endtask

  task automatic tAddrOnly();
    logic a; int w0 = nWr, c0 = nCommit;
    busStart(); sendByte(8'hA8, a); sendByte(8'h03, a); sendByte(8'h45, a); busStop(); tick(4);
    chk("R6 no request address only", nWr - w0, 0);
    chk("R6 no commit address only", nCommit - c0, 0);
  endtask

  task automatic tRandomSeq();
    logic a; logic [7:0] d0, d1, d2;
    busStart(); sendByte(8'hA8, a); sendByte(8'h20, a); sendByte(8'h00, a);
    busStart(); sendByte(8'hA9, a);
    readByte(1'b1, d0); readByte(1'b1, d1); readByte(1'b0, d2);
    chk("R8 random read data", d0, fmem(17'h02000));
    chk("R9 sequential second", d1, fmem(17'h02001));
    chk("R9 sequential third", d2, fmem(17'h02002));
    chk("R9 no drive after nack", sdaOe, 0);
    busStop();
  endtask

  task automatic tWrap();
    logic a; logic [7:0] d0, d1;
    busStart(); sendByte(8'hAA, a); sendByte(8'hFF, a); sendByte(8'hFF, a);
    busStart(); sendByte(8'hAB, a);
    readByte(1'b1, d0); readByte(1'b0, d1); busStop();
    chk("R10 last location", d0, fmem(17'h1FFFF));
    chk("R10 wrapped to zero", d1, fmem(17'h00000));
  endtask

  task automatic tBusy();
    logic a;
    wrBusy = 1'b1;
    busStart(); sendByte(8'hA8, a); busStop();
    chk("R11 nack while busy", a, 0);
    wrBusy = 1'b0; tick(Q);
    busStart(); sendByte(8'hA8, a); busStop();
    chk("R11 ack after busy", a, 1);
  endtask

  task automatic tAbort();
    logic a; logic [7:0] d;
    busStart(); sendByte(8'hA8, a); sendBits(8'hE0, 3);
    busStart(); sendByte(8'hA8, a);
    chk("R12 select after abort acked", a, 1);
    sendByte(8'h07, a); sendByte(8'h77, a);
    busStart(); sendByte(8'hA9, a); readByte(1'b0, d); busStop();
    chk("R12 read after abort", d, fmem(17'h00777));
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishUp();
  end

  initial begin
    tick(4);
    tReset();
    rstN = 1'b1; tick(4);
    tNoStart();
    tWrongSel();
    tByteWrite();
    curRead(8'hAB, 17'h11235, "R7 current read after write");
    curRead(8'hAB, 17'h11236, "R7 current read after read");
    tPageWrap();
    curRead(8'hA9, 17'h00001, "R7 current read after page wrap");
    tAddrOnly();
    curRead(8'hA9, 17'h00345, "R8 read after address-only framing");
    tRandomSeq();
    tWrap();
    curRead(8'hAB, 17'h10001, "R13 select bit16 replaces pointer");
    tBusy();
    tAbort();
    chk("R14 sdaOe changes only with SCL low", badOe, 0);
    finishUp();
  end
endmodule